// File: doc/BRIEF.md
# Shift-Weighted Two-Pass Cost Aggregator with Winner Selection

This block takes census matching costs for a short row segment of a stereo pair and turns them into one disparity per output position. Every cost is weighted by a power of two, so a product is a left shift. Aggregation runs in two passes. First, each incoming column of costs is reduced to a column sum with per-row vertical weight codes. Second, the column sums that fall inside a square window are combined with horizontal weight codes into a final cost. A running minimum per output position keeps the best disparity seen so far. When the last disparity has been aggregated, that position's winner is emitted.

Input arrives on a valid/ready stream, one column per beat. A segment consists of disparity levels 0 to NDISP-1 in that order. Each level has NCOL = NPOS+WIN-1 columns, sent left to right and numbered 0 to NCOL-1 by arrival order. Every beat carries the disparity index, WIN costs, WIN vertical codes and WIN horizontal codes. Lane r of a packed array belongs to window row r. Horizontal lane k of column c is the code used when that column sits at offset k of the window whose first column is c-k.

Column sums go into one bank of a two-bank store while the other bank is read one window position per cycle. A column sum is therefore computed once and shared by every window that overlaps it. in_ready is low only while the bank to be filled still holds sums that have not been read. The output stream obeys standard valid/ready rules. While a result waits for out_ready, reading of the last disparity's bank pauses, and input may back up behind it.

Top module: `sagg_top`

## Requirements
- R1: A cost value above 6 on any lane is treated as 6. Costs of 0 to 6 are used as given.
- R2: A 3-bit weight code of 0 means weight zero. A code k from 1 to 7 means weight 2^(k-1), so the largest weight is 64.
- R3: The column sum of a beat is the sum over rows r of clamped cost r multiplied by the weight of vertical code r.
- R4: The final cost of window position p at disparity d is the sum over k = 0..WIN-1 of the column sum of column p+k multiplied by the weight of horizontal lane k of that same column.
- R5: For each position, the reported disparity is the one with the smallest final cost. When final costs are equal, the smaller disparity wins.
- R6: After the columns of disparity NDISP-1 are accepted, exactly NPOS results leave in position order 0..NPOS-1. No result is produced for any other disparity.
- R7: A beat transfers only in a cycle where in_valid and in_ready are both high. in_ready falls only while drain work is pending. Stalls on either side never change a result.
- R8: Once out_valid is high, it stays high and out_disp stays unchanged until a cycle with out_ready high.
- R9: During and right after reset, out_valid is low and in_ready is high.
- R10: Disparity 0 restarts the minimum search, so nothing carries from one segment into the next.
- R11: With every cost at 6 and every code at 7, the final cost of 1,204,224 is represented without wrapping. Comparisons against it stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Column beat is present |
| in_ready | output | 1 | Column beat can be taken |
| in_disp | input | 6 | Disparity level of the beat |
| in_cost | input | WIN x 3 | Census cost per window row |
| in_vcode | input | WIN x 3 | Vertical weight code per row |
| in_hcode | input | WIN x 3 | Horizontal weight code per window offset |
| out_valid | output | 1 | Winning disparity is present |
| out_ready | input | 1 | Consumer takes the result |
| out_disp | output | 6 | Winning disparity for the next position |

## Verification
The hardest state to reach combines both column banks full, a result held back by a low out_ready, and the next segment's disparity 0 already waiting at the input. In that state, drain stalls, input back-pressure and the restart of the minimum all meet. The stimulus reaches it by sending dense beats with random gaps while dropping out_ready at random for several segments. Other directed segments cover four cases:
- ties across all levels;
- clamped costs that only differ above 6;
- zero weights;
- a level just below a power of two against saturated levels, which would flip the winner if the accumulators wrapped.

// File: rtl/sagg_pkg.sv
package sagg_pkg;
  localparam int COST_W     = 3;
  localparam int CODE_W     = 3;
  localparam int COST_MAX   = 6;
  localparam int WEIGHT_MAX = 64;

  typedef logic [COST_W-1:0] cost_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic cost_t clamp_cost(cost_t c);
    return (c > cost_t'(COST_MAX)) ? cost_t'(COST_MAX) : c;
  endfunction
endpackage

// File: rtl/sagg_vpass.sv
module sagg_vpass
  import sagg_pkg::*;
#(
  parameter int WIN   = 7,
  parameter int COL_W = 12
) (
  input  logic [WIN-1:0][COST_W-1:0] cost,
  input  logic [WIN-1:0][CODE_W-1:0] code,
  output logic [COL_W-1:0]           sum
);
  logic [COL_W-1:0] term [WIN];

  for (genvar r = 0; r < WIN; r++) begin : g_row
    always_comb begin
      if (code[r] == '0) term[r] = '0;
      else term[r] = COL_W'(clamp_cost(cost[r])) << (code[r] - code_t'(1));
    end
  end

  always_comb begin
    sum = '0;
    for (int r = 0; r < WIN; r++) sum = sum + term[r];
  end
endmodule

// File: rtl/sagg_colbuf.sv
module sagg_colbuf
  import sagg_pkg::*;
#(
  parameter int WIN   = 7,
  parameter int NCOL  = 10,
  parameter int COL_W = 12,
  parameter int CW    = 4,
  parameter int PW    = 2
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic                       wbank,
  input  logic [CW-1:0]              waddr,
  input  logic [COL_W-1:0]           wsum,
  input  logic [WIN-1:0][CODE_W-1:0] wcode,
  input  logic                       rbank,
  input  logic [PW-1:0]              rpos,
  output logic [COL_W-1:0]           rsum [WIN],
  output logic [CODE_W-1:0]          rcode [WIN]
);
  logic [COL_W-1:0]           sum_q  [2][NCOL];
  logic [WIN-1:0][CODE_W-1:0] code_q [2][NCOL];

  always_ff @(posedge clk) begin
    if (we) begin
      sum_q[wbank][waddr]  <= wsum;
      code_q[wbank][waddr] <= wcode;
    end
  end

  for (genvar k = 0; k < WIN; k++) begin : g_tap
    logic [CW-1:0] idx;
    assign idx      = CW'(rpos) + CW'(k);
    assign rsum[k]  = sum_q[rbank][idx];
    assign rcode[k] = code_q[rbank][idx][k];
  end
endmodule

// File: rtl/sagg_hpass.sv
module sagg_hpass
  import sagg_pkg::*;
#(
  parameter int WIN   = 7,
  parameter int COL_W = 12,
  parameter int FIN_W = 21
) (
  input  logic [COL_W-1:0]  rsum [WIN],
  input  logic [CODE_W-1:0] rcode [WIN],
  output logic [FIN_W-1:0]  fin
);
  logic [FIN_W-1:0] term [WIN];

  for (genvar k = 0; k < WIN; k++) begin : g_off
    always_comb begin
      if (rcode[k] == '0) term[k] = '0;
      else term[k] = FIN_W'(rsum[k]) << (rcode[k] - code_t'(1));
    end
  end

  always_comb begin
    fin = '0;
    for (int k = 0; k < WIN; k++) fin = fin + term[k];
  end
endmodule

// File: rtl/sagg_wta.sv
module sagg_wta #(
  parameter int NPOS   = 4,
  parameter int PW     = 2,
  parameter int DISP_W = 6,
  parameter int FIN_W  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [PW-1:0]     pos,
  input  logic              first,
  input  logic [DISP_W-1:0] disp,
  input  logic [FIN_W-1:0]  fin,
  output logic [DISP_W-1:0] win_disp
);
  logic [FIN_W-1:0]  min_q  [NPOS];
  logic [DISP_W-1:0] best_q [NPOS];
  logic              take;

  // strict less-than keeps the earlier (smaller) disparity on ties
  assign take     = first || (fin < min_q[pos]);
  assign win_disp = take ? disp : best_q[pos];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPOS; p++) begin
        min_q[p]  <= '0;
        best_q[p] <= '0;
      end
    end else if (step && take) begin
      min_q[pos]  <= fin;
      best_q[pos] <= disp;
    end
  end
endmodule

// File: rtl/sagg_top.sv
module sagg_top
  import sagg_pkg::*;
#(
  parameter int WIN   = 7,
  parameter int NPOS  = 4,
  parameter int NDISP = 64,
  localparam int DISP_W = $clog2(NDISP)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DISP_W-1:0]          in_disp,
  input  logic [WIN-1:0][COST_W-1:0] in_cost,
  input  logic [WIN-1:0][CODE_W-1:0] in_vcode,
  input  logic [WIN-1:0][CODE_W-1:0] in_hcode,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DISP_W-1:0]          out_disp
);
  localparam int NCOL    = NPOS + WIN - 1;
  localparam int CW      = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int PW      = (NPOS > 1) ? $clog2(NPOS) : 1;
  localparam int COL_MAX = WIN * COST_MAX * WEIGHT_MAX;
  localparam int COL_W   = $clog2(COL_MAX + 1);
  localparam int FIN_MAX = COL_MAX * WIN * WEIGHT_MAX;
  localparam int FIN_W   = $clog2(FIN_MAX + 1);

  logic              fill_bank, read_bank;
  logic [1:0]        full_q;
  logic [DISP_W-1:0] tag_q [2];
  logic [CW-1:0]     col_q;
  logic [PW-1:0]     pos_q;

  logic              accept, col_done;
  logic              drain_busy, drain_last, drain_step, pos_done;
  logic [DISP_W-1:0] rd_disp, win_disp;
  logic [COL_W-1:0]  col_sum;
  logic [COL_W-1:0]  rd_sum [WIN];
  logic [CODE_W-1:0] rd_code [WIN];
  logic [FIN_W-1:0]  fin_cost;

  assign in_ready   = !full_q[fill_bank];
  assign accept     = in_valid && in_ready;
  assign col_done   = accept && (col_q == CW'(NCOL - 1));
  assign drain_busy = full_q[read_bank];
  assign rd_disp    = tag_q[read_bank];
  assign drain_last = (rd_disp == DISP_W'(NDISP - 1));
  assign drain_step = drain_busy && !(drain_last && out_valid && !out_ready);
  assign pos_done   = drain_step && (pos_q == PW'(NPOS - 1));

  sagg_vpass #(.WIN(WIN), .COL_W(COL_W)) u_vpass (
    .cost(in_cost), .code(in_vcode), .sum(col_sum)
  );

  sagg_colbuf #(.WIN(WIN), .NCOL(NCOL), .COL_W(COL_W), .CW(CW), .PW(PW)) u_colbuf (
    .clk(clk), .we(accept), .wbank(fill_bank), .waddr(col_q),
    .wsum(col_sum), .wcode(in_hcode),
    .rbank(read_bank), .rpos(pos_q), .rsum(rd_sum), .rcode(rd_code)
  );

  sagg_hpass #(.WIN(WIN), .COL_W(COL_W), .FIN_W(FIN_W)) u_hpass (
    .rsum(rd_sum), .rcode(rd_code), .fin(fin_cost)
  );

  sagg_wta #(.NPOS(NPOS), .PW(PW), .DISP_W(DISP_W), .FIN_W(FIN_W)) u_wta (
    .clk(clk), .rst(rst), .step(drain_step), .pos(pos_q),
    .first(rd_disp == '0), .disp(rd_disp), .fin(fin_cost), .win_disp(win_disp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_bank <= 1'b0;
      read_bank <= 1'b0;
      full_q    <= '0;
      tag_q[0]  <= '0;
      tag_q[1]  <= '0;
      col_q     <= '0;
      pos_q     <= '0;
      out_valid <= 1'b0;
      out_disp  <= '0;
    end else begin
      if (accept) begin
        col_q <= col_done ? '0 : col_q + CW'(1);
        if (col_done) begin
          tag_q[fill_bank] <= in_disp;
          fill_bank        <= !fill_bank;
        end
      end
      for (int b = 0; b < 2; b++) begin
        full_q[b] <= (full_q[b] && !(pos_done && (read_bank == 1'(b))))
                   || (col_done && (fill_bank == 1'(b)));
      end
      if (drain_step) begin
        pos_q <= pos_done ? '0 : pos_q + PW'(1);
        if (pos_done) read_bank <= !read_bank;
      end
      if (drain_step && drain_last) begin
        out_valid <= 1'b1;
        out_disp  <= win_disp;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sagg_top_chk.sv
module sagg_top_chk
  import sagg_pkg::*;
#(
  parameter int WIN     = 7,
  parameter int COL_W   = 12,
  parameter int FIN_W   = 21,
  parameter int DISP_W  = 6,
  parameter int COL_MAX = 2688,
  parameter int FIN_MAX = 1204224
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [WIN-1:0][CODE_W-1:0] in_vcode,
  input logic [COL_W-1:0]           col_sum,
  input logic [CODE_W-1:0]          rd_code [WIN],
  input logic [FIN_W-1:0]           fin_cost,
  input logic                       drain_step,
  input logic                       drain_last,
  input logic                       drain_busy,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DISP_W-1:0]          out_disp
);
  logic hcodes_zero;
  always_comb begin
    hcodes_zero = 1'b1;
    for (int k = 0; k < WIN; k++) if (rd_code[k] != '0) hcodes_zero = 1'b0;
  end

  a_r9_reset_idle: assert property (@(posedge clk) rst |=> !out_valid && in_ready);

  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_disp));

  a_r6_emit_last: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(drain_step && drain_last));

  a_r2_zero_vweight: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_vcode == '0) |-> col_sum == '0);

  a_r4_zero_hweight: assert property (@(posedge clk) disable iff (rst)
    drain_busy && hcodes_zero |-> fin_cost == '0);

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (int'(col_sum) <= COL_MAX) && (int'(fin_cost) <= FIN_MAX));

  a_r7_block_needs_drain: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> drain_busy);
endmodule

bind sagg_top sagg_top_chk #(
  .WIN(WIN), .COL_W(COL_W), .FIN_W(FIN_W), .DISP_W(DISP_W),
  .COL_MAX(COL_MAX), .FIN_MAX(FIN_MAX)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_vcode(in_vcode), .col_sum(col_sum), .rd_code(rd_code),
  .fin_cost(fin_cost), .drain_step(drain_step), .drain_last(drain_last),
  .drain_busy(drain_busy), .out_valid(out_valid), .out_ready(out_ready),
  .out_disp(out_disp)
);

// File: tb/sagg_top_bench.sv
module sagg_top_bench;
  localparam int WIN = 7, NPOS = 4, NDISP = 64, DISP_W = 6;
  localparam int NCOL = NPOS + WIN - 1;
  localparam int NSEG = 12;
  localparam int TOTAL = NSEG * NPOS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [DISP_W-1:0]     in_disp = '0;
  logic [WIN-1:0][2:0]   in_cost = '0, in_vcode = '0, in_hcode = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b0;
  logic [DISP_W-1:0]     out_disp;

  sagg_top u_sagg_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_disp(in_disp), .in_cost(in_cost), .in_vcode(in_vcode), .in_hcode(in_hcode),
    .out_valid(out_valid), .out_ready(out_ready), .out_disp(out_disp)
  );

  int unsigned seed_q [NSEG];
  int          exp_q  [TOTAL];
  int n_chk = 0, n_bad = 0, n_out = 0;
  bit prev_stall = 1'b0;
  logic [DISP_W-1:0] prev_disp = '0;

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int unsigned mix(int unsigned s, int a, int b, int c);
    int unsigned x;
    x = s ^ (a * 32'h9E3779B1) ^ (b * 32'h85EBCA77) ^ (c * 32'hC2B2AE3D);
    x = x ^ (x >> 15); x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12); x = x * 32'h297A2D39;
    return x ^ (x >> 15);
  endfunction

  function automatic int cost_of(int s, int d, int c, int r);
    case (s)
      0: return 3;
      1: return (d == 40) ? 6 : 7;
      2: return (d == NDISP - 1) ? 0 : int'(mix(seed_q[s], d, c, r) % 8);
      8: return (d == 20) ? 5 : 6;
      default: return int'(mix(seed_q[s], d, c, r) % 8);
    endcase
  endfunction

  function automatic int vcode_of(int s, int d, int c, int r);
    case (s)
      0, 1: return 4;
      3: return (d == 0) ? 1 + int'(mix(seed_q[s] ^ 32'h1111, d, c, r) % 7) : 0;
      8: return 7;
      default: return int'(mix(seed_q[s] ^ 32'h1111, d, c, r) % 8);
    endcase
  endfunction

  function automatic int hcode_of(int s, int d, int c, int k);
    case (s)
      0, 1: return 4;
      3: return (d == 0) ? 1 + int'(mix(seed_q[s] ^ 32'h2222, d, c, k) % 7) : int'(mix(seed_q[s] ^ 32'h2222, d, c, k) % 8);
      8: return 7;
      default: return int'(mix(seed_q[s] ^ 32'h2222, d, c, k) % 8);
    endcase
  endfunction

  // R1 clamp, R2 weight encoding
  function automatic longint wt(int code, longint v);
    return (code == 0) ? 0 : (v << (code - 1));
  endfunction

  function automatic int model(int s, int p);
    longint best = 0;
    int bd = 0;
    for (int d = 0; d < NDISP; d++) begin
      longint f = 0;
      for (int k = 0; k < WIN; k++) begin
        longint cs = 0;
        for (int r = 0; r < WIN; r++) begin
          int cv = cost_of(s, d, p + k, r);
          if (cv > 6) cv = 6;
          cs += wt(vcode_of(s, d, p + k, r), cv);
        end
        f += wt(hcode_of(s, d, p + k, k), cs);
      end
      if (d == 0 || f < best) begin best = f; bd = d; end
    end
    return bd;
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R5"; 1: return "R1"; 2: return "R6"; 3: return "R2";
      4: return "R4"; 5: return "R7"; 6: return "R8"; 7: return "R10";
      8: return "R11"; default: return "R3";
    endcase
  endfunction

  // output side: choose ready, record transfers, check holds (R8)
  always @(negedge clk) begin
    if (!rst) begin
      int os = (n_out < TOTAL) ? n_out / NPOS : 0;
      if (prev_stall) begin
        check(out_valid == 1'b1, "R8", int'(out_valid), 1);
        check(out_disp == prev_disp, "R8", int'(out_disp), int'(prev_disp));
      end
      out_ready = (os == 6 || os >= 9) ? (($urandom % 3) != 0) : 1'b1;
      prev_stall = out_valid && !out_ready;
      prev_disp  = out_disp;
      if (out_valid && out_ready) begin
        if (n_out < TOTAL)
          check(int'(out_disp) == exp_q[n_out], tag_of(n_out / NPOS), int'(out_disp), exp_q[n_out]);
        else
          check(1'b0, "R6", n_out + 1, TOTAL);
        n_out++;
      end
    end
  end

  // input side (R7: gaps and back-pressure)
  initial begin
    wait (!rst);
    @(negedge clk);
    for (int s = 0; s < NSEG; s++) begin
      for (int d = 0; d < NDISP; d++) begin
        for (int c = 0; c < NCOL; c++) begin
          while ((s == 5 || s >= 9) && ($urandom % 4) == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
          end
          in_valid = 1'b1;
          in_disp  = DISP_W'(d);
          for (int r = 0; r < WIN; r++) begin
            in_cost[r]  = 3'(cost_of(s, d, c, r));
            in_vcode[r] = 3'(vcode_of(s, d, c, r));
            in_hcode[r] = 3'(hcode_of(s, d, c, r));
          end
          while (!in_ready) @(negedge clk);
          @(negedge clk);
        end
      end
    end
    in_valid = 1'b0;
  end

  initial begin
    void'($urandom(32'd7331));
    for (int s = 0; s < NSEG; s++) seed_q[s] = $urandom;
    for (int i = 0; i < TOTAL; i++) exp_q[i] = model(i / NPOS, i % NPOS);
    // directed expectations stated by the requirements
    check(exp_q[0] == 0, "R5", exp_q[0], 0);
    check(exp_q[NPOS] == 0, "R1", exp_q[NPOS], 0);
    check(exp_q[3 * NPOS] == 1, "R2", exp_q[3 * NPOS], 1);
    check(exp_q[8 * NPOS] == 20, "R11", exp_q[8 * NPOS], 20);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9", int'(in_ready), 1);
    rst = 1'b0;
    begin
      int cyc = 0;
      while (n_out < TOTAL && cyc < 150000) begin
        @(negedge clk);
        cyc++;
      end
      if (n_out < TOTAL) check(1'b0, "R6", n_out, TOTAL);
    end
    repeat (30) @(negedge clk);
    check(n_out == TOTAL, "R6", n_out, TOTAL);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule